// File: doc/BRIEF.md
# Midpoint Ellipse Rasterizer

This block traces the outline of an axis-aligned ellipse with integer arithmetic only. A single start pulse supplies the centre and the two radii. The engine then walks one quadrant of the curve with a midpoint decision variable. Every point it finds is sent out as four mirrored pixels, so the whole outline appears on a valid strobe, one pixel per clock. A drawing pipeline downstream takes these coordinates. The engine raises busy for the whole run and pulses done once when the outline is complete.

The per-point work is spread over numbered sub-steps. Each sub-step adds or subtracts only one or two terms into the 32-bit decision register. The squares and cross products needed at the start of each curve region come from a private two-stage multiplier, which returns its product two clocks after the operands are applied. The first region steps in x while the slope is shallow. The second region steps in y and ends when y drops below zero, which keeps very flat ellipses on the curve.

Top module: `ellipse_raster`

## Requirements
- R1: After reset, busy, done and pix_valid are all low.
- R2: In idle, a start pulse latches cx, cy, rx and ry, and busy is high in the following cycle. A start pulse while busy is high has no effect on the pixels of the run in progress.
- R3: Every computed point (x, y) is emitted as four consecutive valid pixels in this order: (cx+x, cy+y), (cx−x, cy+y), (cx+x, cy−y), (cx−x, cy−y). Coordinates are 12-bit two's-complement and wrap modulo 4096.
- R4: With both radii non-zero, the first region starts from x=0, y=ry, px=0, py=2·rx²·ry and p = ((rx²+2)>>2) + ry² − rx²·ry. It emits the point while px ≤ py. Each step then increments x and adds 2·ry² to px, and p gains ry² + px. If p was positive before the step, y is also decremented, py loses 2·rx², and the new py is subtracted from p.
- R5: The second region starts with p = ((ry²+2)>>2) − rx²·ry² + ry²·x·(x+1) + rx²·(y−1)². It emits the point while y ≥ 0. Each step decrements y, subtracts 2·rx² from py and adds rx² − py to p. If p was not positive before the step, x is also incremented, px gains 2·ry², and px is added to p.
- R6: If ry = 0, the points (k, 0) for k = 0..rx are emitted. Otherwise, if rx = 0, the points (0, k) for k = ry down to 0 are emitted. Both radii zero gives the single point (0, 0). Every case terminates.
- R7: done is high for exactly one cycle, while busy is still high, and busy is low in the next cycle. pix_valid is only high while busy is high.
- R8: Within a run, the point's x never decreases and its y never increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, sampled in idle only |
| cx | input | COORD_W | Centre x, signed |
| cy | input | COORD_W | Centre y, signed |
| rx | input | RAD_W | Horizontal radius, unsigned |
| ry | input | RAD_W | Vertical radius, unsigned |
| pix_valid | output | 1 | Pixel coordinate valid |
| pix_x | output | COORD_W | Pixel x, signed |
| pix_y | output | COORD_W | Pixel y, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with its default 12-bit coordinates and 8-bit radii. Radii are drawn from 0 to 40, so every product, including rx²·ry², stays well inside the 32-bit decision register, and every emitted pixel can be matched exactly against a bench model of the same integer recurrences. The directed cases cover the zero-radius lines, very wide and very tall ellipses, and a centre near the coordinate limit, which brings the 12-bit wrap of the mirrored pixels into reach.

// File: rtl/ellipse_pkg.sv
package ellipse_pkg;

    localparam int WORD_W = 32;

    typedef logic signed [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
    } mul_ops_t;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_I_RX2,
        ST_I_RY2,
        ST_I_CAP_RX2,
        ST_I_CAP_RY2,
        ST_I_QTR,
        ST_I_ADD,
        ST_I_SUB,
        ST_R1_TEST,
        ST_R1_ADV,
        ST_R1_DEC,
        ST_R1_FIX,
        ST_R2_M0,
        ST_R2_M1,
        ST_R2_M2,
        ST_R2_M3,
        ST_R2_M4,
        ST_R2_M5,
        ST_R2_M6,
        ST_R2_TEST,
        ST_R2_ADV,
        ST_R2_DEC,
        ST_R2_FIX,
        ST_LN_TEST,
        ST_LN_STEP,
        ST_EMIT,
        ST_DONE
    } step_e;

    typedef enum logic [1:0] {
        PH_LINE,
        PH_R1,
        PH_R2
    } phase_e;

    // rounded division by four
    function automatic word_t quarter_round(word_t v);
        return (v + word_t'(2)) >>> 2;
    endfunction

endpackage

// File: rtl/ell_mul2.sv
module ell_mul2
    import ellipse_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mul_ops_t ops,
    output word_t    prod
);
    mul_ops_t ops_q;
    word_t    prod_q;
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        ops_q  <= ops;
        prod_q <= ops_q.a * ops_q.b;
    end

    always_ff @(posedge clk) begin
        if (rst)
            warm <= 2'd0;
        else if (warm != 2'd2)
            warm <= warm + 2'd1;
    end

    assign prod = prod_q;

    // R4
    mul_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (prod == $past(ops.a, 2) * $past(ops.b, 2)));

endmodule

// File: rtl/ell_mirror.sv
module ell_mirror #(
    parameter int COORD_W = 12
) (
    input  logic signed [COORD_W-1:0] cx,
    input  logic signed [COORD_W-1:0] cy,
    input  logic signed [COORD_W-1:0] ox,
    input  logic signed [COORD_W-1:0] oy,
    input  logic [1:0]                quad,
    output logic signed [COORD_W-1:0] px,
    output logic signed [COORD_W-1:0] py
);
    always_comb begin
        px = quad[0] ? (cx - ox) : (cx + ox);
        py = quad[1] ? (cy - oy) : (cy + oy);
    end
endmodule

// File: rtl/ellipse_raster.sv
module ellipse_raster
    import ellipse_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int RAD_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic signed [COORD_W-1:0] cx,
    input  logic signed [COORD_W-1:0] cy,
    input  logic [RAD_W-1:0]          rx,
    input  logic [RAD_W-1:0]          ry,
    output logic                      pix_valid,
    output logic signed [COORD_W-1:0] pix_x,
    output logic signed [COORD_W-1:0] pix_y,
    output logic                      busy,
    output logic                      done
);
    localparam int PAD = WORD_W - RAD_W;

    step_e  state;
    phase_e phase;
    logic [1:0] quad;
    logic signed [COORD_W-1:0] cx_q, cy_q;
    logic [RAD_W-1:0] rx_q, ry_q;
    word_t rxw, ryw;
    word_t rx2, ry2, p, px, py, x, y, t, u;
    mul_ops_t ops;
    word_t    prod;

    assign rxw = {{PAD{1'b0}}, rx_q};
    assign ryw = {{PAD{1'b0}}, ry_q};

    ell_mul2 i_mul (
        .clk  (clk),
        .rst  (rst),
        .ops  (ops),
        .prod (prod)
    );

    // operand selection: the product is consumed two states later
    always_comb begin
        ops = '0;
        case (state)
            ST_I_RX2:     begin ops.a = rxw;         ops.b = rxw;         end
            ST_I_RY2:     begin ops.a = ryw;         ops.b = ryw;         end
            ST_I_CAP_RY2: begin ops.a = rx2;         ops.b = ryw;         end
            ST_R2_M0:     begin ops.a = x;           ops.b = x + 1;       end
            ST_R2_M1:     begin ops.a = y - 1;       ops.b = y - 1;       end
            ST_R2_M2:     begin ops.a = rx2;         ops.b = ry2;         end
            ST_R2_M3:     begin ops.a = ry2;         ops.b = t;           end
            ST_R2_M4:     begin ops.a = rx2;         ops.b = u;           end
            default:      ops = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_LINE;
            quad  <= 2'd0;
            cx_q  <= '0;
            cy_q  <= '0;
            rx_q  <= '0;
            ry_q  <= '0;
            rx2   <= '0;
            ry2   <= '0;
            p     <= '0;
            px    <= '0;
            py    <= '0;
            x     <= '0;
            y     <= '0;
            t     <= '0;
            u     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cx_q <= cx;
                    cy_q <= cy;
                    rx_q <= rx;
                    ry_q <= ry;
                    x    <= '0;
                    y    <= {{PAD{1'b0}}, ry};
                    px   <= '0;
                    quad <= 2'd0;
                    if (rx == '0 || ry == '0) begin
                        phase <= PH_LINE;
                        state <= ST_LN_TEST;
                    end else begin
                        phase <= PH_R1;
                        state <= ST_I_RX2;
                    end
                end
                ST_I_RX2:     state <= ST_I_RY2;
                ST_I_RY2:     state <= ST_I_CAP_RX2;
                ST_I_CAP_RX2: begin rx2 <= prod; state <= ST_I_CAP_RY2; end
                ST_I_CAP_RY2: begin ry2 <= prod; state <= ST_I_QTR; end
                ST_I_QTR:     begin p <= quarter_round(rx2); state <= ST_I_ADD; end
                ST_I_ADD: begin
                    p     <= p + ry2;
                    t     <= prod;
                    py    <= prod <<< 1;
                    state <= ST_I_SUB;
                end
                ST_I_SUB:     begin p <= p - t; state <= ST_R1_TEST; end
                ST_R1_TEST: begin
                    if (px <= py) begin
                        state <= ST_EMIT;
                    end else begin
                        phase <= PH_R2;
                        state <= ST_R2_M0;
                    end
                end
                ST_R1_ADV: begin
                    x     <= x + 1;
                    px    <= px + (ry2 <<< 1);
                    state <= ST_R1_DEC;
                end
                ST_R1_DEC: begin
                    p <= p + ry2 + px;
                    if (p > 0) begin
                        y     <= y - 1;
                        py    <= py - (rx2 <<< 1);
                        state <= ST_R1_FIX;
                    end else begin
                        state <= ST_R1_TEST;
                    end
                end
                ST_R1_FIX: begin p <= p - py; state <= ST_R1_TEST; end
                ST_R2_M0: state <= ST_R2_M1;
                ST_R2_M1: state <= ST_R2_M2;
                ST_R2_M2: begin t <= prod; state <= ST_R2_M3; end
                ST_R2_M3: begin u <= prod; state <= ST_R2_M4; end
                ST_R2_M4: begin p <= quarter_round(ry2) - prod; state <= ST_R2_M5; end
                ST_R2_M5: begin p <= p + prod; state <= ST_R2_M6; end
                ST_R2_M6: begin p <= p + prod; state <= ST_R2_TEST; end
                ST_R2_TEST: state <= (y >= 0) ? ST_EMIT : ST_DONE;
                ST_R2_ADV: begin
                    y     <= y - 1;
                    py    <= py - (rx2 <<< 1);
                    state <= ST_R2_DEC;
                end
                ST_R2_DEC: begin
                    p <= p + rx2 - py;
                    if (p > 0) begin
                        state <= ST_R2_TEST;
                    end else begin
                        x     <= x + 1;
                        px    <= px + (ry2 <<< 1);
                        state <= ST_R2_FIX;
                    end
                end
                ST_R2_FIX: begin p <= p + px; state <= ST_R2_TEST; end
                ST_LN_TEST: begin
                    if ((ry_q == '0) ? (x <= rxw) : (y >= 0))
                        state <= ST_EMIT;
                    else
                        state <= ST_DONE;
                end
                ST_LN_STEP: begin
                    if (ry_q == '0)
                        x <= x + 1;
                    else
                        y <= y - 1;
                    state <= ST_LN_TEST;
                end
                ST_EMIT: begin
                    quad <= quad + 2'd1;
                    if (quad == 2'd3) begin
                        case (phase)
                            PH_LINE: state <= ST_LN_STEP;
                            PH_R1:   state <= ST_R1_ADV;
                            default: state <= ST_R2_ADV;
                        endcase
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    ell_mirror #(.COORD_W(COORD_W)) i_mirror (
        .cx   (cx_q),
        .cy   (cy_q),
        .ox   (x[COORD_W-1:0]),
        .oy   (y[COORD_W-1:0]),
        .quad (quad),
        .px   (pix_x),
        .py   (pix_y)
    );

    assign pix_valid = (state == ST_EMIT);
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    // R7
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> busy);

    // R8
    x_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (x >= $past(x)));

    // R8
    y_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (y <= $past(y)));

endmodule

// File: tb/test_ellipse_raster.sv
module test_ellipse_raster;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [CW-1:0] cx = '0, cy = '0;
    logic [RW-1:0] rx = '0, ry = '0;
    logic pix_valid, busy, done;
    logic signed [CW-1:0] pix_x, pix_y;

    int n_chk = 0;
    int n_bad = 0;
    int eq_x[$];
    int eq_y[$];
    string eq_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ellipse_raster #(.COORD_W(CW), .RAD_W(RW)) i_ellipse_raster (
        .clk(clk), .rst(rst), .start(start), .cx(cx), .cy(cy), .rx(rx), .ry(ry),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .busy(busy), .done(done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wrapc(int v);
        logic [CW-1:0] w;
        w = v[CW-1:0];
        return int'($signed(w));
    endfunction

    task automatic push4(int ccx, int ccy, int x, int y, string tag);
        eq_x.push_back(wrapc(ccx + x)); eq_y.push_back(wrapc(ccy + y)); eq_tag.push_back(tag);
        eq_x.push_back(wrapc(ccx - x)); eq_y.push_back(wrapc(ccy + y)); eq_tag.push_back(tag);
        eq_x.push_back(wrapc(ccx + x)); eq_y.push_back(wrapc(ccy - y)); eq_tag.push_back(tag);
        eq_x.push_back(wrapc(ccx - x)); eq_y.push_back(wrapc(ccy - y)); eq_tag.push_back(tag);
    endtask

    // behavioural model of the integer recurrences in R4, R5, R6
    task automatic build(int ccx, int ccy, int a, int b);
        int x, y, p, px, py, a2, b2;
        bit pos;
        eq_x.delete(); eq_y.delete(); eq_tag.delete();
        x = 0; y = b;
        if (a == 0 || b == 0) begin
            while ((b == 0) ? (x <= a) : (y >= 0)) begin
                push4(ccx, ccy, x, y, "R6");
                if (b == 0) x++; else y--;
            end
            return;
        end
        a2 = a * a; b2 = b * b;
        px = 0; py = 2 * a2 * b;
        p = ((a2 + 2) >>> 2) + b2 - a2 * b;
        while (px <= py) begin
            push4(ccx, ccy, x, y, "R4");
            pos = (p > 0);
            x++; px += 2 * b2; p += b2 + px;
            if (pos) begin y--; py -= 2 * a2; p -= py; end
        end
        p = ((b2 + 2) >>> 2) - a2 * b2 + b2 * (x * (x + 1)) + a2 * ((y - 1) * (y - 1));
        while (y >= 0) begin
            push4(ccx, ccy, x, y, "R5");
            pos = (p > 0);
            y--; py -= 2 * a2; p += a2 - py;
            if (!pos) begin x++; px += 2 * b2; p += px; end
        end
    endtask

    task automatic run_one(int ccx, int ccy, int a, int b, bit poke, string tag_over);
        int idx, ex, ey, dx, dy, prevx, prevy;
        string tg;
        bit finished;
        build(ccx, ccy, a, b);
        @(negedge clk);
        start = 1'b1; cx = ccx[CW-1:0]; cy = ccy[CW-1:0]; rx = a[RW-1:0]; ry = b[RW-1:0];
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        idx = 0; prevx = -1; prevy = 1 << 20; finished = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (pix_valid) begin
                if (eq_x.size() == 0) begin
                    chk(1'b0, "R4", "extra pixel", idx, 0);
                end else begin
                    ex = eq_x.pop_front(); ey = eq_y.pop_front(); tg = eq_tag.pop_front();
                    if (tag_over != "") tg = tag_over;
                    chk(int'(pix_x) == ex, tg, "pixel x", int'(pix_x), ex);
                    chk(int'(pix_y) == ey, tg, "pixel y", int'(pix_y), ey);
                end
                if (idx % 4 == 0) begin
                    dx = wrapc(int'(pix_x) - ccx);
                    dy = wrapc(int'(pix_y) - ccy);
                    chk(dx >= prevx && dy <= prevy, "R8", "point order x", dx, prevx);
                    prevx = dx; prevy = dy;
                end
                idx++;
            end
            if (done) begin
                chk(busy == 1'b1, "R7", "busy with done", int'(busy), 1);
                finished = 1'b1;
                break;
            end
            if (poke && c == 3) begin
                start = 1'b1; cx = cx + 12'sd7; rx = rx ^ 8'd5; ry = ry + 8'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(finished, "R7", "run ended", int'(finished), 1);
        chk(eq_x.size() == 0, poke ? "R2" : "R4", "missing pixels", eq_x.size(), 0);
        @(negedge clk);
        chk(!busy && !done, "R7", "idle after done", int'(busy) + 2 * int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pix_valid, "R1", "outputs in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pix_valid, "R1", "outputs after reset", int'(pix_valid), 0);

        run_one(0, 0, 0, 0, 1'b0, "");
        run_one(100, -50, 0, 5, 1'b0, "");
        run_one(10, 10, 9, 0, 1'b0, "");
        run_one(0, 0, 40, 40, 1'b0, "");
        run_one(-300, 200, 40, 1, 1'b0, "");
        run_one(300, -200, 1, 40, 1'b0, "");
        run_one(2040, -2040, 40, 30, 1'b0, "R3");
        run_one(5, 5, 20, 12, 1'b1, "R2");
        for (int a = 0; a <= 40; a++) begin
            run_one(a * 13 - 200, 150 - a * 7, a, (a * 7) % 41, 1'b0, "");
        end
        for (int k = 0; k < 40; k++) begin
            run_one(int'($urandom_range(3000)) - 1500, int'($urandom_range(3000)) - 1500,
                    int'($urandom_range(40)), int'($urandom_range(40)), 1'b0, "");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule